// File: doc/BRIEF.md
# Block-Operation Word Datapath

This block computes one destination word per step of a rectangular block operation over three 16-bit source words. The A source is trimmed by edge masks at the left and right ends of each row. The A and B sources are each realigned by a funnel shift that reaches back into the word seen one step earlier. The three aligned sources are then merged bit by bit through a logic function that eight select bits program. An optional area-fill pass can follow, and it carries its state from word to word within a row.

An external sequencer supplies the source words and marks the first and last word of each row. It pulses `opStart` before each operation. The result of each step appears one clock after its `wordValid`, together with a write-enable. A sticky flag reports whether the whole operation produced only zero bits. Address generation, memory access and line drawing are handled elsewhere.

Top module: `blit_word_path`

## Requirements
- R1: `outValid` is high exactly one clock after a cycle with `wordValid` high and low otherwise. `outData` changes only on those clocks and holds its value between them.
- R2: `srcA` is ANDed with `firstMask` when `rowFirst` is high and with `lastMask` when `rowLast` is high. Both masks apply when both flags are high, and a word with neither flag passes unmasked. Masking happens before the shift.
- R3: The A word used by the logic function is bits [15:0] of the 32-bit value {previous masked A, current masked A} shifted right by `shiftA`. The previous word is taken as zero when `rowFirst` is high.
- R4: The B word is formed the same way from unmasked `srcB`, using `shiftB`, which is independent of `shiftA`. The previous B word is also zero when `rowFirst` is high.
- R5: Each result bit equals `minterm[4*a + 2*b + c]`, where a, b and c are the matching bits of the shifted A, shifted B and raw C words. For example, 8'hF0 copies A, 8'hCC copies B, 8'hAA copies C and 8'hC0 gives A AND B.
- R6: With `fillEn` high, the result is scanned from bit 0 to bit 15 with a fill state. For each bit, the new state equals the old state XOR the bit. Inclusive mode (`fillExcl` low) outputs old state OR bit. Exclusive mode outputs the new state.
- R7: On `rowFirst` the fill state is seeded from `fillCarryIn`. Otherwise it continues from the final state of the previous word in the row. With `fillEn` low, the logic-function result passes unchanged.
- R8: `outWrite` rises with `outValid` only when `destInhibit` was low for that word. An inhibited word still appears on `outData`.
- R9: `zeroFlag` is 1 after reset and one clock after an `opStart` with no word. It is cleared by any word whose final result has a 1 bit, whether or not that word is written, and otherwise holds. When `opStart` and a word coincide, the flag reflects only that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opStart | input | 1 | Start of a new operation; presets the zero flag |
| wordValid | input | 1 | Source words and controls are valid for one step |
| rowFirst | input | 1 | This word is the first of its row |
| rowLast | input | 1 | This word is the last of its row |
| srcA | input | 16 | A source word |
| srcB | input | 16 | B source word |
| srcC | input | 16 | C source word |
| firstMask | input | 16 | Mask for the A word at the row start |
| lastMask | input | 16 | Mask for the A word at the row end |
| shiftA | input | 4 | Right shift amount for A |
| shiftB | input | 4 | Right shift amount for B |
| minterm | input | 8 | Logic function select bits |
| fillEn | input | 1 | Enable area fill |
| fillExcl | input | 1 | 1 selects exclusive fill, 0 inclusive |
| fillCarryIn | input | 1 | Fill state seed at each row start |
| destInhibit | input | 1 | Suppress the write of this word |
| outValid | output | 1 | Result word valid |
| outWrite | output | 1 | Result word is to be written |
| outData | output | 16 | Result word |
| zeroFlag | output | 1 | 1 while every result of the operation has been zero |

## Verification
A table of single-word rows runs the logic function with copy-A, copy-B, copy-C, AND, OR, XOR, all-zero and all-ones selects. The operand patterns are chosen so that each select gives a different answer, which shows that the minterm index order is right. Multi-word rows then show that the funnel shift draws on the previous word only inside a row. They also show that the edge masks reach only the end words, and that fill state runs across word boundaries but is reseeded at each new row. Inclusive fill is tested against exclusive fill, with both carry-in values, to tell the two output rules apart. A sequence of zero, inhibited-nonzero and zero words confirms that the zero flag follows computed data and not written data.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef struct packed {
    logic load;      // a word step is taken this cycle
    logic rowStart;  // clear previous-word state and reseed fill
    logic useFirst;  // apply first-word mask to A
    logic useLast;   // apply last-word mask to A
    logic opStart;   // preset zero-detect flag
    logic writeEn;   // this word may be written
  } blitStrobe_t;
endpackage

// File: rtl/blit_funnel.sv
module blit_funnel #(
  parameter int WORD_W = 16,
  localparam int SHIFT_W = $clog2(WORD_W)
) (
  input  logic [2*WORD_W-1:0] window,
  input  logic [SHIFT_W-1:0]  amt,
  output logic [WORD_W-1:0]   dataOut
);
  logic [2*WORD_W-1:0] shifted;

  always_comb begin
    shifted = window >> amt;
    dataOut = shifted[WORD_W-1:0];
  end
endmodule

// File: rtl/blit_fill.sv
module blit_fill #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] dataIn,
  input  logic              seed,
  input  logic              exclusive,
  output logic [WORD_W-1:0] dataOut,
  output logic              carryOut
);
  logic [WORD_W:0] state;

  assign state[0] = seed;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign state[i+1]  = state[i] ^ dataIn[i];
    assign dataOut[i]  = exclusive ? state[i+1] : (state[i] | dataIn[i]);
  end

  assign carryOut = state[WORD_W];
endmodule

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opStart,
  input  logic        wordValid,
  input  logic        rowFirst,
  input  logic        rowLast,
  input  logic        destInhibit,
  output blitStrobe_t strobe,
  output logic        outValid,
  output logic        outWrite
);
  always_comb begin
    strobe.load     = wordValid;
    strobe.rowStart = wordValid & rowFirst;
    strobe.useFirst = rowFirst;
    strobe.useLast  = rowLast;
    strobe.opStart  = opStart;
    strobe.writeEn  = wordValid & ~destInhibit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWrite <= 1'b0;
    end else begin
      outValid <= strobe.load;
      outWrite <= strobe.writeEn;
    end
  end
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SHIFT_W = $clog2(WORD_W),
  localparam int NUM_SHIFTED = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  blitStrobe_t        strobe,
  input  logic [WORD_W-1:0]  srcA,
  input  logic [WORD_W-1:0]  srcB,
  input  logic [WORD_W-1:0]  srcC,
  input  logic [WORD_W-1:0]  firstMask,
  input  logic [WORD_W-1:0]  lastMask,
  input  logic [SHIFT_W-1:0] shiftA,
  input  logic [SHIFT_W-1:0] shiftB,
  input  logic [7:0]         minterm,
  input  logic               fillEn,
  input  logic               fillExcl,
  input  logic               fillCarryIn,
  output logic [WORD_W-1:0]  outData,
  output logic               zeroFlag
);
  logic [WORD_W-1:0]  maskedA;
  logic [WORD_W-1:0]  curWord   [NUM_SHIFTED];
  logic [WORD_W-1:0]  prevWord  [NUM_SHIFTED];
  logic [WORD_W-1:0]  alignWord [NUM_SHIFTED];
  logic [SHIFT_W-1:0] amtSel    [NUM_SHIFTED];
  logic [WORD_W-1:0]  logicRes;
  logic [WORD_W-1:0]  fillRes;
  logic [WORD_W-1:0]  finalRes;
  logic               fillState;
  logic               fillSeed;
  logic               fillCarryOut;

  // Edge masking of the A source before alignment
  always_comb begin
    maskedA = srcA;
    if (strobe.useFirst) maskedA = maskedA & firstMask;
    if (strobe.useLast)  maskedA = maskedA & lastMask;
  end

  assign curWord[0] = maskedA;
  assign curWord[1] = srcB;
  assign amtSel[0]  = shiftA;
  assign amtSel[1]  = shiftB;

  // One funnel shifter and one history register per shifted source
  for (genvar s = 0; s < NUM_SHIFTED; s++) begin : g_src
    logic [WORD_W-1:0] histSel;

    assign histSel = strobe.rowStart ? '0 : prevWord[s];

    blit_funnel #(.WORD_W(WORD_W)) u_funnel (
      .window  ({histSel, curWord[s]}),
      .amt     (amtSel[s]),
      .dataOut (alignWord[s])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            prevWord[s] <= '0;
      else if (strobe.load) prevWord[s] <= curWord[s];
    end
  end

  // Programmable three-input function, one lookup per bit
  for (genvar i = 0; i < WORD_W; i++) begin : g_logic
    assign logicRes[i] = minterm[{alignWord[0][i], alignWord[1][i], srcC[i]}];
  end

  assign fillSeed = strobe.rowStart ? fillCarryIn : fillState;

  blit_fill #(.WORD_W(WORD_W)) u_fill (
    .dataIn    (logicRes),
    .seed      (fillSeed),
    .exclusive (fillExcl),
    .dataOut   (fillRes),
    .carryOut  (fillCarryOut)
  );

  assign finalRes = fillEn ? fillRes : logicRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillState <= 1'b0;
      outData   <= '0;
    end else if (strobe.load) begin
      fillState <= fillCarryOut;
      outData   <= finalRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroFlag <= 1'b1;
    end else if (strobe.load) begin
      zeroFlag <= (strobe.opStart | zeroFlag) & ~(|finalRes);
    end else if (strobe.opStart) begin
      zeroFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/blit_word_path.sv
module blit_word_path
  import blit_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int SHIFT_W = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               opStart,
  input  logic               wordValid,
  input  logic               rowFirst,
  input  logic               rowLast,
  input  logic [WORD_W-1:0]  srcA,
  input  logic [WORD_W-1:0]  srcB,
  input  logic [WORD_W-1:0]  srcC,
  input  logic [WORD_W-1:0]  firstMask,
  input  logic [WORD_W-1:0]  lastMask,
  input  logic [SHIFT_W-1:0] shiftA,
  input  logic [SHIFT_W-1:0] shiftB,
  input  logic [7:0]         minterm,
  input  logic               fillEn,
  input  logic               fillExcl,
  input  logic               fillCarryIn,
  input  logic               destInhibit,
  output logic               outValid,
  output logic               outWrite,
  output logic [WORD_W-1:0]  outData,
  output logic               zeroFlag
);
  blitStrobe_t strobe;

  blit_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opStart     (opStart),
    .wordValid   (wordValid),
    .rowFirst    (rowFirst),
    .rowLast     (rowLast),
    .destInhibit (destInhibit),
    .strobe      (strobe),
    .outValid    (outValid),
    .outWrite    (outWrite)
  );

  blit_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .srcA        (srcA),
    .srcB        (srcB),
    .srcC        (srcC),
    .firstMask   (firstMask),
    .lastMask    (lastMask),
    .shiftA      (shiftA),
    .shiftB      (shiftB),
    .minterm     (minterm),
    .fillEn      (fillEn),
    .fillExcl    (fillExcl),
    .fillCarryIn (fillCarryIn),
    .outData     (outData),
    .zeroFlag    (zeroFlag)
  );
endmodule

// File: rtl/blit_word_path_chk.sv
module blit_word_path_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              opStart,
  input logic              wordValid,
  input logic              destInhibit,
  input logic              outValid,
  input logic              outWrite,
  input logic [WORD_W-1:0] outData,
  input logic              zeroFlag
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> outValid);

  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> !outValid);

  a_r1_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> $stable(outData));

  a_r8_write_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    outWrite |-> outValid);

  a_r8_inhibit_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && destInhibit) |=> !outWrite);

  a_r9_preset: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && !wordValid) |=> zeroFlag);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!opStart && !zeroFlag) |=> !zeroFlag);

  a_r9_nonzero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outData != '0)) |-> !zeroFlag);
endmodule

bind blit_word_path blit_word_path_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opStart     (opStart),
  .wordValid   (wordValid),
  .destInhibit (destInhibit),
  .outValid    (outValid),
  .outWrite    (outWrite),
  .outData     (outData),
  .zeroFlag    (zeroFlag)
);

// File: tb/blit_word_path_bench.sv
module blit_word_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 14;

  typedef struct packed {
    logic [15:0] a, b, c, fm, lm;
    logic [3:0]  sa, sb;
    logic [7:0]  mt;
    logic        fe, fx, ci;
    logic [15:0] expect_v;
  } vec_t;

  // Single-word rows: both masks apply, previous words are zero
  localparam vec_t VECS [NUM_VEC] = '{
    '{16'h1234, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hF0, 1'b0, 1'b0, 1'b0, 16'h1234}, // R5 copy A
    '{16'h0000, 16'hABCD, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd4, 8'hCC, 1'b0, 1'b0, 1'b0, 16'h0ABC}, // R4/R5 copy B shifted
    '{16'hFFFF, 16'h0000, 16'h5A5A, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hAA, 1'b0, 1'b0, 1'b0, 16'h5A5A}, // R5 copy C
    '{16'hFF00, 16'h0FF0, 16'h1234, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hC0, 1'b0, 1'b0, 1'b0, 16'h0F00}, // R5 A and B
    '{16'hF000, 16'h000F, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hFC, 1'b0, 1'b0, 1'b0, 16'hF00F}, // R5 A or B
    '{16'hFFFF, 16'h00FF, 16'hAAAA, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'h3C, 1'b0, 1'b0, 1'b0, 16'hFF00}, // R5 A xor B
    '{16'hFFFF, 16'h0000, 16'h0000, 16'h0FFF, 16'hFFF0, 4'd0, 4'd0, 8'hF0, 1'b0, 1'b0, 1'b0, 16'h0FF0}, // R2 both masks
    '{16'h8000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd15,4'd0, 8'hF0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R3 max shift
    '{16'h0042, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hF0, 1'b1, 1'b0, 1'b0, 16'h007E}, // R6 inclusive
    '{16'h0042, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hF0, 1'b1, 1'b1, 1'b0, 16'h003E}, // R6 exclusive
    '{16'h0010, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hF0, 1'b1, 1'b0, 1'b1, 16'h001F}, // R7 seed 1 incl
    '{16'h0010, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'hF0, 1'b1, 1'b1, 1'b1, 16'h000F}, // R7 seed 1 excl
    '{16'hBEEF, 16'hCAFE, 16'h1357, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000}, // R5 none
    '{16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 4'd0, 4'd0, 8'h01, 1'b0, 1'b0, 1'b0, 16'hFFFF}  // R5 not-all
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opStart = 1'b0, wordValid = 1'b0, rowFirst = 1'b0, rowLast = 1'b0;
  logic [15:0] srcA = '0, srcB = '0, srcC = '0, firstMask = '1, lastMask = '1;
  logic [3:0]  shiftA = '0, shiftB = '0;
  logic [7:0]  minterm = 8'hF0;
  logic        fillEn = 1'b0, fillExcl = 1'b0, fillCarryIn = 1'b0, destInhibit = 1'b0;
  logic        outValid, outWrite, zeroFlag;
  logic [15:0] outData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blit_word_path u_blit_word_path (
    .clk(clk), .rstN(rstN), .opStart(opStart), .wordValid(wordValid),
    .rowFirst(rowFirst), .rowLast(rowLast), .srcA(srcA), .srcB(srcB), .srcC(srcC),
    .firstMask(firstMask), .lastMask(lastMask), .shiftA(shiftA), .shiftB(shiftB),
    .minterm(minterm), .fillEn(fillEn), .fillExcl(fillExcl), .fillCarryIn(fillCarryIn),
    .destInhibit(destInhibit), .outValid(outValid), .outWrite(outWrite),
    .outData(outData), .zeroFlag(zeroFlag)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where results are visible
  task automatic step(input logic first, input logic last);
    rowFirst  = first;
    rowLast   = last;
    wordValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic pulseStart();
    opStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opStart = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset outValid", {15'd0, outValid}, 16'd0);
    check("R8 reset outWrite", {15'd0, outWrite}, 16'd0);
    check("R9 reset zeroFlag", {15'd0, zeroFlag}, 16'd1);
    check("R1 reset outData", outData, 16'h0000);

    // Table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      srcA = VECS[i].a; srcB = VECS[i].b; srcC = VECS[i].c;
      firstMask = VECS[i].fm; lastMask = VECS[i].lm;
      shiftA = VECS[i].sa; shiftB = VECS[i].sb; minterm = VECS[i].mt;
      fillEn = VECS[i].fe; fillExcl = VECS[i].fx; fillCarryIn = VECS[i].ci;
      step(1'b1, 1'b1);
      check($sformatf("R5 vector %0d data", i), outData, VECS[i].expect_v);
      check($sformatf("R1 vector %0d valid", i), {15'd0, outValid}, 16'd1);
    end
    fillEn = 1'b0; fillCarryIn = 1'b0; firstMask = '1; lastMask = '1;
    shiftB = '0;

    // R1: idle cycle drops valid and holds data
    @(negedge clk);
    check("R1 idle valid low", {15'd0, outValid}, 16'd0);
    check("R1 idle data held", outData, 16'hFFFF);

    // R3: A shift pulls from previous word within a row, cleared at row start
    minterm = 8'hF0; shiftA = 4'd4;
    srcA = 16'hABCD; step(1'b1, 1'b0);
    check("R3 first word shift", outData, 16'h0ABC);
    srcA = 16'h1234; step(1'b0, 1'b1);
    check("R3 second word uses previous", outData, 16'hD123);
    srcA = 16'h5678; step(1'b1, 1'b1);
    check("R3 new row clears previous", outData, 16'h0567);
    shiftA = 4'd0;

    // R4: B shift independent of A
    minterm = 8'hCC; shiftB = 4'd8; shiftA = 4'd3;
    srcA = 16'hFFFF;
    srcB = 16'h00FF; step(1'b1, 1'b0);
    check("R4 B first word", outData, 16'h0000);
    srcB = 16'h0000; step(1'b0, 1'b1);
    check("R4 B second word", outData, 16'hFF00);
    shiftB = 4'd0; shiftA = 4'd0;

    // R2: masks reach only end words of a three-word row
    minterm = 8'hF0; firstMask = 16'h00FF; lastMask = 16'hFF00; srcA = 16'hFFFF;
    step(1'b1, 1'b0);
    check("R2 first mask", outData, 16'h00FF);
    step(1'b0, 1'b0);
    check("R2 middle unmasked", outData, 16'hFFFF);
    step(1'b0, 1'b1);
    check("R2 last mask", outData, 16'hFF00);
    firstMask = '1; lastMask = '1;

    // R7: fill state carries across words in a row, reseeds at row start
    fillEn = 1'b1; fillExcl = 1'b0; fillCarryIn = 1'b0;
    srcA = 16'h0100; step(1'b1, 1'b0);
    check("R7 fill word0", outData, 16'hFF00);
    srcA = 16'h0000; step(1'b0, 1'b0);
    check("R7 fill carried", outData, 16'hFFFF);
    srcA = 16'h0001; step(1'b0, 1'b1);
    check("R7 fill closes", outData, 16'h0001);
    srcA = 16'h0100; step(1'b1, 1'b0);
    srcA = 16'h0000; step(1'b1, 1'b1);
    check("R7 reseed at row start", outData, 16'h0000);
    fillEn = 1'b0;

    // R8/R9: inhibit and zero detect
    pulseStart();
    check("R9 preset by opStart", {15'd0, zeroFlag}, 16'd1);
    srcA = 16'h0000; destInhibit = 1'b0; step(1'b1, 1'b1);
    check("R8 write when not inhibited", {15'd0, outWrite}, 16'd1);
    check("R9 zero word keeps flag", {15'd0, zeroFlag}, 16'd1);
    srcA = 16'h0400; destInhibit = 1'b1; step(1'b1, 1'b1);
    check("R8 inhibited no write", {15'd0, outWrite}, 16'd0);
    check("R8 inhibited data visible", outData, 16'h0400);
    check("R9 inhibited nonzero clears", {15'd0, zeroFlag}, 16'd0);
    srcA = 16'h0000; destInhibit = 1'b0; step(1'b1, 1'b1);
    check("R9 flag sticky", {15'd0, zeroFlag}, 16'd0);
    pulseStart();
    check("R9 second opStart presets", {15'd0, zeroFlag}, 16'd1);

    // R9: opStart coinciding with a zero word after a cleared flag
    srcA = 16'h0001; step(1'b1, 1'b1);
    check("R9 cleared before coincide", {15'd0, zeroFlag}, 16'd0);
    srcA = 16'h0000; opStart = 1'b1; step(1'b1, 1'b1); opStart = 1'b0;
    check("R9 coincident start and zero word", {15'd0, zeroFlag}, 16'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule